// File: doc/BRIEF.md
# Reference Clock Request Gating

This block decides, one cycle at a time, whether each of seven differential reference clock outputs (numbered 1 to 7) runs, is held stopped while still driven, or is placed in high impedance. It merges three sources: an eight-bit enable byte from the register file, two active-low clock-request pins, and a mode strap. The strap is latched once, when the power-good input first goes low, and decides whether the two request pins are request inputs or act as the extra output pair number 6.

Two register fields choose which output each request pin controls. The register file is expected to reset them to 4 for pin A and 5 for pin B. Each output has its own boundary strobe, which marks a clock edge of that output's own clock. The enable and tristate state of an output changes only on its strobe, so a gated output is never cut in the middle of a period.

Top module: `refclk_req_gate`

## Requirements
- R1: From reset until the strap has been latched, every output has run_o=0 and hiz_o=1, whatever the enables and requests are.
- R2: The strap is captured on the first clock edge where pwrgd_n is low. Later changes on pwrgd_n or on the strap pin have no effect on the outputs.
- R3: Output i (1..7) can run only when bit i of en_reg is 1. Bit 0 of en_reg has no effect.
- R4: A map field of value k (1..7) assigns its request pin to output k, and the value 0 assigns it to no output. If both fields name the same output, both pins must be low for that output to run.
- R5: Request pins are active low and pass through a two-flop synchronizer. With the output's strobe held high, a pin change made before edge k appears on run_o after edge k+2 and not earlier.
- R6: With the strap latched at 0, output 6 has run_o=0 and hiz_o=1 whatever bit 6 of en_reg is.
- R7: With the strap latched at 1, the request pins and map fields are ignored. Each output, including output 6, runs exactly when its enable bit is 1.
- R8: hiz_o[i] is 1 exactly when output i is disabled by its enable bit, is missing (R6) or is blocked by R1. An output stopped only by a request is driven, with run_o=0 and hiz_o=0.
- R9: run_o[i] and hiz_o[i] change only after an edge where bnd_i[i] is 1. Otherwise they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwrgd_n | input | 1 | Active-low power-good; the first low latches the strap |
| strap_pins_out | input | 1 | Mode strap: 0 = request inputs, 1 = pins form output 6 |
| en_reg | input | N_OUT+1 | Enable byte; bit i enables output i; bit 0 unused |
| map_a | input | MAP_W | Output number gated by request pin A (0 = none) |
| map_b | input | MAP_W | Output number gated by request pin B (0 = none) |
| req_a_n | input | 1 | Request pin A, active low, asynchronous |
| req_b_n | input | 1 | Request pin B, active low, asynchronous |
| bnd_i | input | N_OUT | Per-output clock boundary strobe (bit 1 is output 1) |
| run_o | output | N_OUT | Per-output run enable |
| hiz_o | output | N_OUT | Per-output tristate select |

## Verification
Two events can hit the same output in the same cycle: a register enable change and a synchronized request change. Both map fields can also name the same output, so both pins act on it at once. The random phases drive the enable byte, both map fields (often made equal) and both pins together, change them all on the same negative edge, and compare the settled outputs with a model that applies the enable, both requests and the mode. Directed steps measure the synchronizer latency on an exact edge, and check that an output whose strobe is held low stays put while its enable changes.

// File: rtl/refclk_req_gate.sv
module refclk_req_gate #(
  parameter int N_OUT   = 7,
  parameter int PIN_OUT = 6,
  localparam int MAP_W  = $clog2(N_OUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwrgd_n,
  input  logic             strap_pins_out,
  input  logic [N_OUT:0]   en_reg,
  input  logic [MAP_W-1:0] map_a,
  input  logic [MAP_W-1:0] map_b,
  input  logic             req_a_n,
  input  logic             req_b_n,
  input  logic [N_OUT:1]   bnd_i,
  output logic [N_OUT:1]   run_o,
  output logic [N_OUT:1]   hiz_o
);

  logic       locked, pins_out;
  logic [1:0] sync_a, sync_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      locked   <= 1'b0;
      pins_out <= 1'b0;
    end else if (!locked && !pwrgd_n) begin
      locked   <= 1'b1;
      pins_out <= strap_pins_out;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_a <= 2'b11;
      sync_b <= 2'b11;
    end else begin
      sync_a <= {sync_a[0], req_a_n};
      sync_b <= {sync_b[0], req_b_n};
    end

  wire req_mode = ~pins_out;

  for (genvar i = 1; i <= N_OUT; i++) begin : g_out
    wire present  = (i != PIN_OUT) || pins_out;
    wire blk_a    = req_mode && (map_a == MAP_W'(i)) && sync_a[1];
    wire blk_b    = req_mode && (map_b == MAP_W'(i)) && sync_b[1];
    wire want_run = locked && present && en_reg[i] && !blk_a && !blk_b;
    wire want_hiz = !locked || !present || !en_reg[i];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        run_o[i] <= 1'b0;
        hiz_o[i] <= 1'b1;
      end else if (bnd_i[i]) begin
        run_o[i] <= want_run;
        hiz_o[i] <= want_hiz;
      end

    a_r9_hold_off_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd_i[i] |=> $stable(run_o[i]) && $stable(hiz_o[i]));
    a_r8_hiz_not_running: assert property (@(posedge clk) disable iff (!rst_n)
      hiz_o[i] |-> !run_o[i]);
    a_r3_enable_needed: assert property (@(posedge clk) disable iff (!rst_n)
      bnd_i[i] && !en_reg[i] |=> !run_o[i] && hiz_o[i]);
    a_r1_unlocked_off: assert property (@(posedge clk) disable iff (!rst_n)
      bnd_i[i] && !locked |=> hiz_o[i]);
    a_r7_pins_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      bnd_i[i] && locked && pins_out && en_reg[i] |=> run_o[i] && !hiz_o[i]);
    if (i == PIN_OUT) begin : g_pin
      a_r6_pair_absent: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_i[i] && locked && !pins_out |=> hiz_o[i] && !run_o[i]);
    end
  end

  a_r2_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked && $stable(pins_out));

endmodule

// File: tb/refclk_req_gate_bench.sv
module refclk_req_gate_bench;
  localparam int CLK_P = 10;

  logic       clk = 0, rst_n = 0, pwrgd_n = 1, strap = 0;
  logic [7:0] en = 8'hFF;
  logic [2:0] ma = 3'd4, mb = 3'd5;
  logic       ra = 1, rb = 1;
  logic [7:1] bnd = 7'h7F;
  logic [7:1] run, hiz;
  int         errors = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;

  refclk_req_gate u_refclk_req_gate (
    .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .strap_pins_out(strap),
    .en_reg(en), .map_a(ma), .map_b(mb), .req_a_n(ra), .req_b_n(rb),
    .bnd_i(bnd), .run_o(run), .hiz_o(hiz));

  function automatic logic [7:1] m_run(bit lk, bit pm, logic [7:0] e,
                                       logic [2:0] a, logic [2:0] b, bit qa, bit qb);
    logic [7:1] r;
    for (int i = 1; i <= 7; i++) begin
      bit pres = (i != 6) || pm;
      bit blk  = !pm && ((a == 3'(i) && qa) || (b == 3'(i) && qb));
      r[i] = lk && pres && e[i] && !blk;
    end
    return r;
  endfunction

  function automatic logic [7:1] m_hiz(bit lk, bit pm, logic [7:0] e);
    logic [7:1] h;
    for (int i = 1; i <= 7; i++) h[i] = !lk || ((i == 6) && !pm) || !e[i];
    return h;
  endfunction

  task automatic chk(string req, logic [7:1] ar, logic [7:1] er,
                     logic [7:1] ah, logic [7:1] eh);
    checks++;
    if (ar !== er || ah !== eh) begin
      errors++;
      $display("FAIL %s run=%b exp %b hiz=%b exp %b", req, ar, er, ah, eh);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(bit s);
    rst_n = 0; pwrgd_n = 1; strap = s; bnd = 7'h7F;
    cycles(3);
    rst_n = 1;
    cycles(3);
    chk("R1 before power-good", run, 7'h00, hiz, 7'h7F);
    pwrgd_n = 0;
    cycles(4);
  endtask

  task automatic rand_phase(bit pm, int n);
    for (int k = 0; k < n; k++) begin
      en = 8'($urandom);
      ma = 3'($urandom);
      mb = ($urandom % 4 == 0) ? ma : 3'($urandom);
      ra = 1'($urandom); rb = 1'($urandom);
      strap = 1'($urandom); pwrgd_n = 1'($urandom);
      cycles(4);
      chk(pm ? "R7/R2 random pin mode" : "R3/R4/R8/R2 random request mode",
          run, m_run(1, pm, en, ma, mb, ra, rb), hiz, m_hiz(1, pm, en));
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    en = 8'hFF; ra = 0; rb = 0;
    do_reset(0);
    chk("R6 request mode pair 6 absent", run, m_run(1, 0, en, ma, mb, 0, 0),
        hiz, m_hiz(1, 0, en));
    rand_phase(0, 300);

    pwrgd_n = 0; strap = 1;
    en = 8'hFE; ma = 3; mb = 0; ra = 1; rb = 1;
    cycles(4);
    chk("R8 request stop stays driven", run, 7'b1011011, hiz, 7'b0100000);
    ra = 0;
    cycles(2);
    chk("R5 not before third edge", run, 7'b1011011, hiz, 7'b0100000);
    cycles(1);
    chk("R5 on third edge", run, 7'b1011111, hiz, 7'b0100000);

    bnd[2] = 0; en[2] = 0;
    cycles(3);
    chk("R9 held without boundary", run, 7'b1011111, hiz, 7'b0100000);
    bnd[2] = 1;
    cycles(1);
    chk("R9 applied at boundary", run, 7'b1011101, hiz, 7'b0100010);

    en = 8'hFF; ma = 5; mb = 5; ra = 0; rb = 1;
    cycles(4);
    chk("R4 shared output one pin high", run, 7'b1001111, hiz, 7'b0100000);
    rb = 0;
    cycles(4);
    chk("R4 shared output both low", run, 7'b1011111, hiz, 7'b0100000);
    en = 8'h01; ma = 0; mb = 0;
    cycles(4);
    chk("R3 bit 0 has no effect", run, 7'h00, hiz, 7'h7F);

    do_reset(1);
    en = 8'hFF; ma = 6; mb = 1; ra = 1; rb = 1; strap = 0; pwrgd_n = 1;
    cycles(4);
    chk("R7 pins ignored pair 6 runs", run, 7'h7F, hiz, 7'h00);
    rand_phase(1, 300);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule